// File: doc/BRIEF.md
# Show-Ahead Synchronous FIFO

A single-clock queue built on a flop array, with a build-time choice of how the read side behaves. In show-ahead mode the oldest stored word already sits on the read data port, flagged valid, before anyone asks for it. The read strobe then works as an acknowledge that removes that word. In standard mode nothing is presented until a read is accepted, and the word arrives one clock after the strobe, marked by a one-cycle valid pulse.

The advantage of show-ahead mode appears when a word is written into an empty queue. It becomes visible one clock sooner than in standard mode. Once the queue holds data, both modes advance one word per accepted read. Occupancy is tracked with write and read pointers that carry one extra wrap bit. The empty and full flags are decoded from these edge-triggered registers, so they change only at a rising clock edge.

Top module: `fifo_fwft`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `empty` is 1, `full` is 0 and `rd_valid` is 0.
- R2: In show-ahead mode (MODE = FIFO_SHOWAHEAD), a word written into an empty queue appears on `rd_data` with `rd_valid` = 1 on the cycle after the write edge, with `rd_en` held low.
- R3: In show-ahead mode, a read accepted at an edge removes the presented word. The next stored word is on `rd_data` after that same edge. If the queue held one word and a write happened on that edge, the newly written word is the one presented.
- R4: In standard mode (MODE = FIFO_STD), `rd_valid` is 1 for exactly the cycle after an accepted read, and `rd_data` then carries the popped word. In every other cycle `rd_valid` is 0.
- R5: Words leave the queue in the order in which they were accepted.
- R6: `full` is 1 when DEPTH words are stored. A write while full with `rd_en` low is dropped and changes neither the flags nor the stored words.
- R7: A write and a read at the same edge on a full queue are both accepted, and the queue stays full.
- R8: A read while empty is ignored. `rd_valid` stays 0, `empty` stays 1, and the read position does not move, so a later write followed by a read returns that written word.
- R9: In show-ahead mode, `rd_valid` equals the inverse of `empty` in every cycle.
- R10: `empty` and `full` are never 1 together. Each changes only after an edge where an access was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | Queue holds DEPTH words |
| rd_en | input | 1 | Read request (acknowledge in show-ahead mode) |
| rd_data | output | WIDTH | Presented or returned word |
| empty | output | 1 | Queue holds no words |
| rd_valid | output | 1 | `rd_data` carries a valid word |

## Verification
Both modes are built side by side and driven with identical stimulus, so each cycle shows the one-clock gap between them. The stimulus covers:
- a read of an empty queue, which separates an ignored read from one that moves the read pointer;
- a write into an empty queue with no read, which shows whether show-ahead presentation happens;
- a pop and a write together at one-word occupancy, which shows whether the incoming word is forwarded to the output;
- a fill past capacity, which separates dropped writes from overwrites;
- a read and a write together at full, which shows whether both are accepted;
- a full drain with back-to-back reads, which exposes ordering and wrap-bit faults.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    typedef enum logic {
        FIFO_STD       = 1'b0,
        FIFO_SHOWAHEAD = 1'b1
    } fifo_mode_e;

    typedef struct packed {
        logic full;
        logic empty;
    } fifo_flags_t;

endpackage

// File: rtl/fifo_ptrs.sv
module fifo_ptrs #(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    output logic                  wr_ok,
    output logic                  rd_ok,
    output logic [AW-1:0]         wr_addr,
    output logic [AW-1:0]         rd_addr,
    output fifo_pkg::fifo_flags_t flags
);
    logic [AW:0] wp;
    logic [AW:0] rp;

    assign flags.empty = (wp == rp);
    assign flags.full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

    assign rd_ok = rd_en && !flags.empty;
    assign wr_ok = wr_en && (!flags.full || rd_ok);

    assign wr_addr = wp[AW-1:0];
    assign rd_addr = rp[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_ok,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr] <= wr_data;
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/fifo_fwft.sv
module fifo_fwft #(
    parameter int                   WIDTH = 8,
    parameter int                   DEPTH = 4,
    parameter fifo_pkg::fifo_mode_e MODE  = fifo_pkg::FIFO_SHOWAHEAD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             rd_valid
);
    localparam int AW = $clog2(DEPTH);

    logic                  wr_ok;
    logic                  rd_ok;
    logic [AW-1:0]         wr_addr;
    logic [AW-1:0]         rd_addr;
    logic [WIDTH-1:0]      rd_word;
    fifo_pkg::fifo_flags_t flags;

    fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .flags   (flags)
    );

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_ok   (wr_ok),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    assign full  = flags.full;
    assign empty = flags.empty;

    generate
        if (MODE == fifo_pkg::FIFO_SHOWAHEAD) begin : g_showahead
            // head word is always exposed; acknowledge pops it
            assign rd_data  = rd_word;
            assign rd_valid = !flags.empty;
        end else begin : g_standard
            logic [WIDTH-1:0] data_q;
            logic             valid_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q  <= '0;
                    valid_q <= 1'b0;
                end else begin
                    valid_q <= rd_ok;
                    if (rd_ok) data_q <= rd_word;
                end
            end
            assign rd_data  = data_q;
            assign rd_valid = valid_q;
        end
    endgenerate
endmodule

// File: rtl/fifo_fwft_chk.sv
module fifo_fwft_chk #(
    parameter fifo_pkg::fifo_mode_e MODE = fifo_pkg::FIFO_SHOWAHEAD
) (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic full,
    input logic empty,
    input logic rd_valid
);
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (empty && !full && !rd_valid));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full);

    p_full_rw_r7: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en) |=> full);

    p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && !rd_valid));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    p_empty_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (empty && !wr_en) |=> empty);

    generate
        if (MODE == fifo_pkg::FIFO_SHOWAHEAD) begin : g_sa
            p_valid_mirror_r9: assert property (@(posedge clk) disable iff (rst)
                rd_valid == !empty);
        end else begin : g_std
            p_valid_cause_r4: assert property (@(posedge clk) disable iff (rst)
                rd_valid |-> $past(rd_en && !empty));
            p_valid_follow_r4: assert property (@(posedge clk) disable iff (rst)
                (rd_en && !empty) |=> rd_valid);
        end
    endgenerate
endmodule

bind fifo_fwft fifo_fwft_chk #(.MODE(MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .full     (full),
    .empty    (empty),
    .rd_valid (rd_valid)
);

// File: tb/fifo_fwft_tb.sv
module fifo_fwft_tb;
    localparam int W = 8;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;

    logic         sa_full, sa_empty, sa_valid;
    logic [W-1:0] sa_data;
    logic         st_full, st_empty, st_valid;
    logic [W-1:0] st_data;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] sb[$];
    logic         exp_std_v;
    logic [W-1:0] exp_std_d;

    always #5 clk = ~clk;

    fifo_fwft #(.WIDTH(W), .DEPTH(D), .MODE(fifo_pkg::FIFO_SHOWAHEAD)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(sa_full),
        .rd_en(rd_en), .rd_data(sa_data), .empty(sa_empty), .rd_valid(sa_valid)
    );

    fifo_fwft #(.WIDTH(W), .DEPTH(D), .MODE(fifo_pkg::FIFO_STD)) u_dut_std (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(st_full),
        .rd_en(rd_en), .rd_data(st_data), .empty(st_empty), .rd_valid(st_valid)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compare both instances against the scoreboard queue
    task automatic compare(input string tag);
        bit e = (sb.size() == 0);
        bit f = (sb.size() == D);
        chk(sa_empty == e, tag, "sa empty", sa_empty, e);
        chk(sa_full == f, tag, "sa full", sa_full, f);
        chk(st_empty == e, tag, "std empty", st_empty, e);
        chk(st_full == f, tag, "std full", st_full, f);
        chk(sa_valid == !e, "R9", "sa valid", sa_valid, !e);
        if (!e) chk(sa_data == sb[0], tag, "sa head", sa_data, sb[0]);
        chk(st_valid == exp_std_v, tag, "std valid", st_valid, exp_std_v);
        if (exp_std_v) chk(st_data == exp_std_d, tag, "std data", st_data, exp_std_d);
    endtask

    // driver: one clock of stimulus, starting and ending at a falling edge
    task automatic cyc(input bit we, input logic [W-1:0] d, input bit re,
                       input string tag);
        bit rok = re && (sb.size() != 0);
        bit wok = we && ((sb.size() < D) || rok);
        wr_en   = we;
        wr_data = d;
        rd_en   = re;
        exp_std_v = rok;
        exp_std_d = rok ? sb[0] : '0;
        @(posedge clk);
        #1;
        if (rok) void'(sb.pop_front());
        if (wok) sb.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        compare(tag);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_std_v = 1'b0;
        exp_std_d = '0;
        repeat (2) @(negedge clk);
        chk(sa_empty && !sa_full && !sa_valid, "R1", "sa reset state", {sa_empty, sa_full, sa_valid}, 3'b100);
        chk(st_empty && !st_full && !st_valid, "R1", "std reset state", {st_empty, st_full, st_valid}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        compare("R1");

        cyc(0, 8'h00, 1, "R8");           // read of empty queue ignored
        cyc(1, 8'h11, 0, "R2");           // appears at show-ahead port unrequested
        chk(sa_data == 8'h11 && sa_valid, "R2", "sa first word", sa_data, 8'h11);
        chk(!st_valid, "R2", "std waits for read", st_valid, 0);
        cyc(0, 8'h00, 0, "R9");
        cyc(1, 8'h22, 1, "R3");           // pop at one word plus write
        chk(sa_data == 8'h22, "R3", "sa forwarded write", sa_data, 8'h22);
        cyc(0, 8'h00, 1, "R4");           // std returns 22 one clock later
        chk(st_valid && st_data == 8'h22, "R4", "std return", st_data, 8'h22);
        cyc(0, 8'h00, 0, "R4");           // pulse lasts one cycle
        chk(!st_valid, "R4", "std pulse ends", st_valid, 0);
        cyc(1, 8'h33, 0, "R8");
        cyc(0, 8'h00, 1, "R8");
        chk(st_data == 8'h33, "R8", "pointer unmoved by empty read", st_data, 8'h33);

        for (int i = 0; i < D; i++) cyc(1, 8'hA0 + 8'(i), 0, "R6");
        chk(sa_full && st_full, "R6", "full at depth", {sa_full, st_full}, 2'b11);
        cyc(1, 8'hEE, 0, "R6");           // dropped
        cyc(1, 8'h55, 1, "R7");           // accepted at full
        chk(sa_full && sa_data == 8'hA1, "R7", "full kept, head advanced", sa_data, 8'hA1);
        for (int i = 0; i < D; i++) cyc(0, 8'h00, 1, "R5");
        chk(st_data == 8'h55, "R5", "last word out", st_data, 8'h55);
        cyc(0, 8'h00, 1, "R8");
        chk(!st_valid && sa_empty, "R8", "drained read ignored", st_valid, 0);

        for (int i = 0; i < 12; i++) cyc(1, 8'h40 + 8'(i), (i % 3) != 0, "R5");
        for (int i = 0; i < D + 1; i++) cyc(0, 8'h00, 1, "R5");
        cyc(0, 8'h00, 0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule